// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block tracks the clock-control power state of a processor core. A halt instruction parks the core in an automatic halt state. A stop-clock request parks it in a stop-grant state. Once the stop-grant acknowledge transaction has finished, a sleep request can take it further into a sleep state in which every internal clock is stopped.

From either the halt state or the stop-grant state, a bus snoop can pull the core briefly into a snoop-service state. The controller remembers where each excursion started, so that every exit lands in the state the excursion began from. The outputs are the current state code, the core-clock enable, a flag showing whether the bus-clock domain is active, and two single-cycle requests. One request starts the halt bus cycle and the other starts the stop-grant acknowledge bus cycle.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0 (running), `core_clk_en` and `bus_clk_active` are 1, and `halt_cycle` and `grant_ack_req` are 0. The state codes are: running 0, auto-halt 1, stop-grant 2, snoop-service 3, sleep 4.
- R2: In the running state without `stop_clk`, `halt_exec` moves the state to auto-halt at the next edge. `halt_cycle` is 1 for exactly the first cycle of an entry from running, and is 0 for a return into auto-halt from another state.
- R3: In auto-halt, any bit of `wake_evt` (init, bus-init, interrupt, non-maskable interrupt, management interrupt) returns the state to running. `stop_clk` takes priority over a wake event.
- R4: `stop_clk` in running or auto-halt moves the state to stop-grant, and `grant_ack_req` is 1 for exactly the first cycle after that entry. In running, `stop_clk` takes priority over `halt_exec`.
- R5: In stop-grant, a low `stop_clk` returns the state to whichever of running or auto-halt it came from, with neither pulse raised.
- R6: `snoop_req` in auto-halt, or in stop-grant while `stop_clk` stays high, enters snoop-service, and `snoop_done` returns to the state it came from. In auto-halt a wake event beats a snoop.
- R7: Sleep is entered only from stop-grant, with `sleep_req` high and a `grant_ack_done` recorded in an earlier stop-grant cycle since the last fresh entry from running or auto-halt. The record survives snoop and sleep excursions.
- R8: In sleep, only a low `sleep_req` has an effect, and it returns the state to stop-grant. `snoop_req`, `stop_clk` and `wake_evt` are ignored there.
- R9: `core_clk_en` is 1 only in running. `bus_clk_active` is 0 only in sleep.
- R10: `core_reset` forces the running state at the next edge from any state, raises no pulse, and clears the acknowledge record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| halt_exec | input | 1 | Halt instruction executed |
| stop_clk | input | 1 | Stop-clock request, level |
| sleep_req | input | 1 | Sleep request, level |
| snoop_req | input | 1 | Snoop event pending |
| snoop_done | input | 1 | Snoop has been serviced |
| grant_ack_done | input | 1 | Stop-grant acknowledge transaction completed |
| wake_evt | input | WAKE_W | Wake events: init, bus-init, interrupt, NMI, management interrupt |
| core_reset | input | 1 | Core reset event, synchronous |
| state_o | output | 3 | Current state code |
| core_clk_en | output | 1 | Core clock enable |
| bus_clk_active | output | 1 | Bus-clock domain running |
| halt_cycle | output | 1 | One-cycle request for the halt bus cycle |
| grant_ack_req | output | 1 | One-cycle request for the stop-grant acknowledge bus cycle |

## Verification
Two pairs of functions can collide in one cycle. The first pair is the acknowledge-completion record and the sleep request: both arrive in the same stop-grant cycle, and the bench expects the state to stay in stop-grant for that cycle and to reach sleep one edge later. The second pair is a snoop or wake competing with a stop-clock change: directed steps raise both together in auto-halt and in stop-grant, and the bench judges the result against the stated priority. Seeded random stimulus keeps the levels held long enough to reach sleep, then lets snoops, wake events and core resets land on every state, and compares each cycle with a reference model built from the requirements.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_RUN   = 3'd0,
    PS_HALT  = 3'd1,
    PS_GRANT = 3'd2,
    PS_SNOOP = 3'd3,
    PS_SLEEP = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwr_state_next.sv
module pwr_state_next
  import pwr_state_pkg::*;
#(
  parameter int unsigned WAKE_W = 5
) (
  input  pwr_state_e        state_q,
  input  pwr_state_e        grant_ret_q,
  input  pwr_state_e        snoop_ret_q,
  input  logic              acked_q,
  input  logic              halt_exec,
  input  logic              stop_clk,
  input  logic              sleep_req,
  input  logic              snoop_req,
  input  logic              snoop_done,
  input  logic              grant_ack_done,
  input  logic [WAKE_W-1:0] wake_evt,
  input  logic              core_reset,
  output pwr_state_e        state_d,
  output logic              grant_ret_we,
  output logic              snoop_ret_we,
  output logic              acked_d,
  output logic              halt_cyc_d,
  output logic              grant_req_d
);
  logic any_wake;
  assign any_wake = |wake_evt;

  always_comb begin
    state_d      = state_q;
    grant_ret_we = 1'b0;
    snoop_ret_we = 1'b0;
    acked_d      = acked_q;
    halt_cyc_d   = 1'b0;
    grant_req_d  = 1'b0;
    if (core_reset) begin
      state_d = PS_RUN;
      acked_d = 1'b0;
    end else begin
      unique case (state_q)
        PS_RUN: begin
          if (stop_clk) begin
            state_d      = PS_GRANT;
            grant_ret_we = 1'b1;
            grant_req_d  = 1'b1;
            acked_d      = 1'b0;
          end else if (halt_exec) begin
            state_d    = PS_HALT;
            halt_cyc_d = 1'b1;
          end
        end
        PS_HALT: begin
          if (stop_clk) begin
            state_d      = PS_GRANT;
            grant_ret_we = 1'b1;
            grant_req_d  = 1'b1;
            acked_d      = 1'b0;
          end else if (any_wake) begin
            state_d = PS_RUN;
          end else if (snoop_req) begin
            state_d      = PS_SNOOP;
            snoop_ret_we = 1'b1;
          end
        end
        PS_GRANT: begin
          if (grant_ack_done) acked_d = 1'b1;
          if (!stop_clk) begin
            state_d = grant_ret_q;
          end else if (snoop_req) begin
            state_d      = PS_SNOOP;
            snoop_ret_we = 1'b1;
          end else if (sleep_req && acked_q) begin
            state_d = PS_SLEEP;
          end
        end
        PS_SNOOP: begin
          if (snoop_done) state_d = snoop_ret_q;
        end
        PS_SLEEP: begin
          if (!sleep_req) state_d = PS_GRANT;
        end
        default: state_d = PS_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pwr_state_out.sv
module pwr_state_out
  import pwr_state_pkg::*;
(
  input  pwr_state_e state_q,
  output logic       core_clk_en,
  output logic       bus_clk_active
);
  always_comb begin
    core_clk_en    = (state_q == PS_RUN);
    bus_clk_active = (state_q != PS_SLEEP);
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int unsigned WAKE_W     = 5,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_exec,
  input  logic              stop_clk,
  input  logic              sleep_req,
  input  logic              snoop_req,
  input  logic              snoop_done,
  input  logic              grant_ack_done,
  input  logic [WAKE_W-1:0] wake_evt,
  input  logic              core_reset,
  output logic [STATE_W-1:0] state_o,
  output logic              core_clk_en,
  output logic              bus_clk_active,
  output logic              halt_cycle,
  output logic              grant_ack_req
);
  logic       srst_n;
  pwr_state_e state_q, state_d;
  pwr_state_e grant_ret_q, snoop_ret_q;
  logic       grant_ret_we, snoop_ret_we;
  logic       acked_q, acked_d;
  logic       halt_cyc_d, grant_req_d;

  pwr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pwr_state_next #(.WAKE_W(WAKE_W)) u_next (
    .state_q        (state_q),
    .grant_ret_q    (grant_ret_q),
    .snoop_ret_q    (snoop_ret_q),
    .acked_q        (acked_q),
    .halt_exec      (halt_exec),
    .stop_clk       (stop_clk),
    .sleep_req      (sleep_req),
    .snoop_req      (snoop_req),
    .snoop_done     (snoop_done),
    .grant_ack_done (grant_ack_done),
    .wake_evt       (wake_evt),
    .core_reset     (core_reset),
    .state_d        (state_d),
    .grant_ret_we   (grant_ret_we),
    .snoop_ret_we   (snoop_ret_we),
    .acked_d        (acked_d),
    .halt_cyc_d     (halt_cyc_d),
    .grant_req_d    (grant_req_d)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q       <= PS_RUN;
      acked_q       <= 1'b0;
      halt_cycle    <= 1'b0;
      grant_ack_req <= 1'b0;
    end else begin
      state_q       <= state_d;
      acked_q       <= acked_d;
      halt_cycle    <= halt_cyc_d;
      grant_ack_req <= grant_req_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      grant_ret_q <= PS_RUN;
      snoop_ret_q <= PS_HALT;
    end else begin
      if (grant_ret_we) grant_ret_q <= state_q;
      if (snoop_ret_we) snoop_ret_q <= state_q;
    end
  end

  pwr_state_out u_out (
    .state_q        (state_q),
    .core_clk_en    (core_clk_en),
    .bus_clk_active (bus_clk_active)
  );

  assign state_o = state_q;
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk #(
  parameter int unsigned WAKE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snoop_req,
  input logic              sleep_req,
  input logic              core_reset,
  input logic [2:0]        state_o,
  input logic              core_clk_en,
  input logic              bus_clk_active,
  input logic              halt_cycle,
  input logic              grant_ack_req
);
  localparam logic [2:0] S_RUN = 3'd0, S_HALT = 3'd1, S_GRANT = 3'd2,
                         S_SNOOP = 3'd3, S_SLEEP = 3'd4;

  p_sleep_from_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_SLEEP && $past(state_o) != S_SLEEP) |-> $past(state_o) == S_GRANT);

  p_halt_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cycle |-> (state_o == S_HALT && $past(state_o) == S_RUN));

  p_grant_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_ack_req |-> (state_o == S_GRANT &&
                       ($past(state_o) == S_RUN || $past(state_o) == S_HALT)));

  p_sleep_ignores_snoop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_SLEEP && snoop_req && sleep_req && !core_reset) |=> state_o == S_SLEEP);

  p_core_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> (state_o == S_RUN && !halt_cycle && !grant_ack_req));

  p_snoop_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == S_SNOOP && state_o != S_SNOOP && !$past(core_reset))
      |-> (state_o == S_HALT || state_o == S_GRANT));

  p_sleep_clocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == S_SLEEP |-> (!bus_clk_active && !core_clk_en));

  p_pulses_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({halt_cycle, grant_ack_req}) <= 1);
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(.WAKE_W(WAKE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .snoop_req      (snoop_req),
  .sleep_req      (sleep_req),
  .core_reset     (core_reset),
  .state_o        (state_o),
  .core_clk_en    (core_clk_en),
  .bus_clk_active (bus_clk_active),
  .halt_cycle     (halt_cycle),
  .grant_ack_req  (grant_ack_req)
);

// File: tb/pwr_state_ctrl_test.sv
module pwr_state_ctrl_test;
  localparam int WAKE_W = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, halt_exec, stop_clk, sleep_req, snoop_req, snoop_done;
  logic              grant_ack_done, core_reset;
  logic [WAKE_W-1:0] wake_evt;
  logic [2:0]        state_o;
  logic              core_clk_en, bus_clk_active, halt_cycle, grant_ack_req;

  pwr_state_ctrl #(.WAKE_W(WAKE_W)) uut (
    .clk(clk), .rst_n(rst_n), .halt_exec(halt_exec), .stop_clk(stop_clk),
    .sleep_req(sleep_req), .snoop_req(snoop_req), .snoop_done(snoop_done),
    .grant_ack_done(grant_ack_done), .wake_evt(wake_evt), .core_reset(core_reset),
    .state_o(state_o), .core_clk_en(core_clk_en), .bus_clk_active(bus_clk_active),
    .halt_cycle(halt_cycle), .grant_ack_req(grant_ack_req)
  );

  int n_chk = 0, n_fail = 0;
  int m_st = 0, m_gret = 0, m_sret = 1, m_ack = 0, m_hc = 0, m_gr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements
  task automatic mdl_step();
    int nxt = m_st, gret = m_gret, sret = m_sret, ack = m_ack, hc = 0, gr = 0;
    if (core_reset) begin
      nxt = 0; ack = 0;
    end else begin
      case (m_st)
        0: if (stop_clk) begin nxt = 2; gret = 0; gr = 1; ack = 0; end
           else if (halt_exec) begin nxt = 1; hc = 1; end
        1: if (stop_clk) begin nxt = 2; gret = 1; gr = 1; ack = 0; end
           else if (|wake_evt) nxt = 0;
           else if (snoop_req) begin nxt = 3; sret = 1; end
        2: begin
             if (grant_ack_done) ack = 1;
             if (!stop_clk) nxt = m_gret;
             else if (snoop_req) begin nxt = 3; sret = 2; end
             else if (sleep_req && m_ack != 0) nxt = 4;
           end
        3: if (snoop_done) nxt = m_sret;
        default: if (!sleep_req) nxt = 2;
      endcase
    end
    m_st = nxt; m_gret = gret; m_sret = sret; m_ack = ack; m_hc = hc; m_gr = gr;
  endtask

  task automatic check_all(input string tag);
    chk(int'(state_o) == m_st, tag, int'(state_o), m_st);
    chk(core_clk_en == (m_st == 0), "R9 core_clk_en", core_clk_en, m_st == 0);
    chk(bus_clk_active == (m_st != 4), "R9 bus_clk_active", bus_clk_active, m_st != 4);
    chk(halt_cycle == m_hc[0], "R2 halt_cycle", halt_cycle, m_hc);
    chk(grant_ack_req == m_gr[0], "R4 grant_ack_req", grant_ack_req, m_gr);
  endtask

  task automatic cyc(input string tag);
    mdl_step();
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle();
    halt_exec = 0; snoop_req = 0; snoop_done = 0; grant_ack_done = 0;
    wake_evt = '0; core_reset = 0;
  endtask

  function automatic string tag_of(input int st, input logic rst);
    if (rst) return "R10 random";
    case (st)
      0: return "R4 random running";
      1: return "R3 random halt";
      2: return "R7 random grant";
      3: return "R6 random snoop";
      default: return "R8 random sleep";
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; stop_clk = 0; sleep_req = 0; idle();
    @(negedge clk); @(negedge clk);
    chk(state_o == 3'd0, "R1 reset state", state_o, 0);
    chk(core_clk_en && bus_clk_active, "R1 reset clocks", {core_clk_en, bus_clk_active}, 3);
    chk(!halt_cycle && !grant_ack_req, "R1 reset pulses", {halt_cycle, grant_ack_req}, 0);
    rst_n = 1;
    repeat (3) cyc("R1 after release");

    // R2: halt entry with one-cycle pulse
    halt_exec = 1; cyc("R2 halt entry"); halt_exec = 0;
    chk(halt_cycle == 1'b1, "R2 pulse present", halt_cycle, 1);
    cyc("R2 pulse ends");
    // R6/R3: wake beats snoop in auto-halt
    snoop_req = 1; wake_evt = 5'b00100; cyc("R6 wake beats snoop");
    wake_evt = '0; snoop_req = 0;
    halt_exec = 1; cyc("R2 halt again"); halt_exec = 0;
    snoop_req = 1; cyc("R6 snoop from halt"); snoop_req = 0;
    snoop_done = 1; cyc("R6 return to halt"); snoop_done = 0;
    chk(state_o == 3'd1 && !halt_cycle, "R2 no pulse on return", state_o, 1);
    // R3: stop_clk beats wake
    stop_clk = 1; wake_evt = 5'b00001; cyc("R3 stop_clk beats wake"); wake_evt = '0;
    chk(grant_ack_req == 1'b1, "R4 grant pulse", grant_ack_req, 1);
    // R7: ack and sleep in the same cycle stay in stop-grant
    sleep_req = 1; grant_ack_done = 1; cyc("R7 same cycle stays grant");
    grant_ack_done = 0;
    chk(state_o == 3'd2, "R7 not sleep yet", state_o, 2);
    cyc("R7 sleep next cycle");
    chk(state_o == 3'd4, "R7 sleep reached", state_o, 4);
    // R8: ignored inputs in sleep
    snoop_req = 1; wake_evt = 5'b11111; stop_clk = 0; cyc("R8 sleep ignores");
    chk(state_o == 3'd4, "R8 still sleep", state_o, 4);
    snoop_req = 0; wake_evt = '0; stop_clk = 1;
    sleep_req = 0; cyc("R8 sleep release");
    // R7: record kept across snoop
    snoop_req = 1; cyc("R6 snoop from grant"); snoop_req = 0;
    snoop_done = 1; cyc("R6 return to grant"); snoop_done = 0;
    sleep_req = 1; cyc("R7 record kept");
    chk(state_o == 3'd4, "R7 record kept sleep", state_o, 4);
    sleep_req = 0; cyc("R8 back to grant");
    stop_clk = 0; cyc("R5 return to halt");
    chk(state_o == 3'd1 && !halt_cycle, "R5 origin halt no pulse", state_o, 1);
    wake_evt = 5'b10000; cyc("R3 wake to run"); wake_evt = '0;
    // R4: stop_clk beats halt in running; record cleared
    stop_clk = 1; halt_exec = 1; cyc("R4 stop_clk beats halt"); halt_exec = 0;
    sleep_req = 1; cyc("R7 record cleared");
    chk(state_o == 3'd2, "R7 no sleep without ack", state_o, 2);
    grant_ack_done = 1; cyc("R7 ack"); grant_ack_done = 0;
    cyc("R7 sleep");
    core_reset = 1; cyc("R10 reset from sleep"); core_reset = 0;
    chk(state_o == 3'd0, "R10 running", state_o, 0);
    stop_clk = 0; sleep_req = 0; cyc("R5 settle");

    // Seeded random phase
    for (int i = 0; i < 4000; i++) begin
      string t;
      if ($urandom % 16 == 0) stop_clk = ~stop_clk;
      if ($urandom % 8 == 0)  sleep_req = ~sleep_req;
      halt_exec      = ($urandom % 4 == 0);
      snoop_req      = ($urandom % 6 == 0);
      snoop_done     = ($urandom % 3 == 0);
      grant_ack_done = ($urandom % 4 == 0);
      wake_evt       = ($urandom % 10 == 0) ? WAKE_W'(1 << ($urandom % WAKE_W)) : '0;
      core_reset     = ($urandom % 100 == 0);
      t = tag_of(m_st, core_reset);
      cyc(t);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule